// File: doc/BRIEF.md
# Three-Lane Block FIR Filter

This block is a three-tap FIR filter that computes three output samples per block cycle. A serial stream of signed samples enters with a valid flag. A gather stage collects three valid samples into one block word. Three filter lanes then compute the three outputs of that block together. Each lane combines samples from the current block with the last two samples of the previous block, which are kept in history registers. An emit stage sends the three results out one per cycle, oldest first.

The whole block runs on one clock, the sample clock. The block clock is not a separate clock: it is the one-cycle pulse that the gather stage raises when a block is complete, and the lane registers load only on that pulse. Each lane's combinational path is one multiplier followed by an adder tree of three terms. Parameter PROD_REG adds an optional register after the multipliers, which costs one more cycle of latency. The coefficients are static inputs and are changed only while the stream is idle.

Top module: `tri_lane_fir`

## Requirements
- R1: Reset is synchronous and active high. While reset is held, and in the cycle after it, out_vld is low. After reset the gather phase is zero and both history samples are zero, so the first output after reset equals coef_a times the first sample.
- R2: A block is formed only from three valid input samples. Cycles with smp_vld low do not advance the gather phase. A partial block of one or two samples produces no output, however long the stream stays idle.
- R3: The first output of block k is Y(3k) = a·X(3k) + b·X(3k−1) + c·X(3k−2).
- R4: The second output of block k is Y(3k+1) = a·X(3k+1) + b·X(3k) + c·X(3k−1).
- R5: The third output of block k is Y(3k+2) = a·X(3k+2) + b·X(3k+1) + c·X(3k).
- R6: The two history samples X(3k−1) and X(3k−2) carry over from the previous block, including across idle gaps of any length.
- R7: Each completed block produces exactly three outputs in consecutive cycles, in the order Y(3k), Y(3k+1), Y(3k+2). No output appears without a completed block.
- R8: With PROD_REG=0, the third output of a block appears on out_dat four cycles after the sample edge that captured its third input. The first output of the block appears two cycles after that same edge.
- R9: All arithmetic is signed two's complement. out_dat is DW+CW+2 bits wide, so the full-scale products of all three taps add up without overflow.
- R10: A reset asserted in the middle of a stream discards any partial block and clears both history samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Input sample qualifier |
| smp_dat | input | DW | Signed input sample |
| coef_a | input | CW | Signed tap weight applied to the newest sample |
| coef_b | input | CW | Signed tap weight applied to the sample one step older |
| coef_c | input | CW | Signed tap weight applied to the sample two steps older |
| out_vld | output | 1 | Output sample qualifier |
| out_dat | output | DW+CW+2 | Signed filtered sample |

## Verification
The filter is driven with an impulse, a step, an alternating-sign sequence, a ramp and a mix of near-full-scale values. The impulse exposes which tap each lane applies to which sample position. The step and the ramp show whether history is carried between blocks. The alternating signs catch sign-extension faults in the adder tree. Idle gaps of different lengths are placed at every block phase, to show that the phase only advances on valid samples. A stranded partial block, a reset in the middle of a stream and all-negative full-scale operands exercise history clearing and the width of the output.

// File: rtl/fir3_pkg.sv
package fir3_pkg;
   // Number of samples handled per block cycle.
   localparam int NLANE = 3;
   // Number of filter taps.
   localparam int NTAP  = 3;
   // Number of samples from the previous block that each block needs.
   localparam int HIST  = NTAP - 1;
   // Width of the gather phase counter.
   localparam int PHW   = $clog2(NLANE);
   // Width of the emit counter, which counts from NLANE down to zero.
   localparam int CNW   = $clog2(NLANE + 1);
endpackage

// File: rtl/fir3_gather.sv
module fir3_gather
   import fir3_pkg::*;
#(
   parameter int DW = 12
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   smp_vld,
   input  logic [DW-1:0]          smp_dat,
   output logic                   blk_vld,
   output logic [NLANE*DW-1:0]    blk_word,
   output logic [PHW-1:0]         phase
);
   localparam int PW = (NLANE - 1) * DW;

   // Samples already collected for the current block.
   logic [PW-1:0] part;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase    <= '0;
         blk_vld  <= 1'b0;
         part     <= '0;
         blk_word <= '0;
      end else begin
         blk_vld <= 1'b0;
         if (smp_vld) begin
            if (phase == PHW'(NLANE - 1)) begin
               // The last sample of the block completes the word.
               // The oldest sample of the block sits in the lowest slice.
               blk_word <= {smp_dat, part};
               blk_vld  <= 1'b1;
               phase    <= '0;
            end else begin
               part[int'(phase)*DW +: DW] <= smp_dat;
               phase <= phase + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/fir3_lanes.sv
module fir3_lanes
   import fir3_pkg::*;
#(
   parameter int DW       = 12,
   parameter int CW       = 10,
   parameter int OW       = DW + CW + 2,
   parameter bit PROD_REG = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  blk_vld,
   input  logic [NLANE*DW-1:0]   blk_word,
   input  logic [NTAP*CW-1:0]    coef_flat,
   output logic                  y_vld,
   output logic [NLANE*OW-1:0]   y_word
);
   localparam int PRW = DW + CW;
   localparam int EXT = HIST + NLANE;

   logic signed [CW-1:0]  coef  [NTAP];
   logic signed [DW-1:0]  hist  [HIST];
   logic signed [DW-1:0]  ext   [EXT];
   logic signed [PRW-1:0] prod  [NLANE][NTAP];
   logic signed [PRW-1:0] prod_q[NLANE][NTAP];
   logic signed [OW-1:0]  acc   [NLANE];
   logic                  stage_vld;

   // Split the flat coefficient vector into one weight per tap.
   // Tap 0 is applied to the newest sample.
   for (genvar t = 0; t < NTAP; t++) begin : g_coef
      assign coef[t] = $signed(coef_flat[t*CW +: CW]);
   end

   // Sample window: the history samples first, then the current block.
   for (genvar h = 0; h < HIST; h++) begin : g_ext_h
      assign ext[h] = hist[h];
   end
   for (genvar j = 0; j < NLANE; j++) begin : g_ext_c
      assign ext[HIST + j] = $signed(blk_word[j*DW +: DW]);
   end

   // Keep the last HIST samples of each block for the block that follows.
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int h = 0; h < HIST; h++) hist[h] <= '0;
      end else if (blk_vld) begin
         for (int h = 0; h < HIST; h++)
            hist[h] <= $signed(blk_word[(NLANE-HIST+h)*DW +: DW]);
      end
   end

   // Lane j applies tap t to the sample t steps older than its own sample.
   for (genvar j = 0; j < NLANE; j++) begin : g_lane
      for (genvar t = 0; t < NTAP; t++) begin : g_tap
         assign prod[j][t] = coef[t] * ext[HIST + j - t];
      end
   end

   if (PROD_REG) begin : g_preg
      always_ff @(posedge clk) begin
         if (rst) begin
            stage_vld <= 1'b0;
            for (int j = 0; j < NLANE; j++)
               for (int t = 0; t < NTAP; t++) prod_q[j][t] <= '0;
         end else begin
            stage_vld <= blk_vld;
            if (blk_vld)
               for (int j = 0; j < NLANE; j++)
                  for (int t = 0; t < NTAP; t++) prod_q[j][t] <= prod[j][t];
         end
      end
   end else begin : g_pcomb
      assign stage_vld = blk_vld;
      for (genvar j = 0; j < NLANE; j++) begin : g_pl
         for (genvar t = 0; t < NTAP; t++) begin : g_pt
            assign prod_q[j][t] = prod[j][t];
         end
      end
   end

   // Adder tree per lane. Each product is sign-extended to the output width.
   always_comb begin
      for (int j = 0; j < NLANE; j++) begin
         acc[j] = '0;
         for (int t = 0; t < NTAP; t++) acc[j] = acc[j] + OW'(prod_q[j][t]);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         y_vld  <= 1'b0;
         y_word <= '0;
      end else begin
         y_vld <= stage_vld;
         if (stage_vld)
            for (int j = 0; j < NLANE; j++) y_word[j*OW +: OW] <= acc[j];
      end
   end
endmodule

// File: rtl/fir3_emit.sv
module fir3_emit
   import fir3_pkg::*;
#(
   parameter int OW = 24
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 y_vld,
   input  logic [NLANE*OW-1:0]  y_word,
   output logic                 out_vld,
   output logic [OW-1:0]        out_dat
);
   logic [NLANE*OW-1:0] shreg;
   logic [CNW-1:0]      cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg <= '0;
         cnt   <= '0;
      end else if (y_vld) begin
         // A new block takes priority; the previous burst ends in this same cycle.
         shreg <= y_word;
         cnt   <= CNW'(NLANE);
      end else if (cnt != '0) begin
         shreg <= shreg >> OW;
         cnt   <= cnt - 1'b1;
      end
   end

   assign out_vld = (cnt != '0);
   assign out_dat = shreg[OW-1:0];
endmodule

// File: rtl/tri_lane_fir.sv
module tri_lane_fir
   import fir3_pkg::*;
#(
   parameter int DW       = 12,
   parameter int CW       = 10,
   parameter bit PROD_REG = 1'b0,
   localparam int OW      = DW + CW + 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 smp_vld,
   input  logic signed [DW-1:0] smp_dat,
   input  logic signed [CW-1:0] coef_a,
   input  logic signed [CW-1:0] coef_b,
   input  logic signed [CW-1:0] coef_c,
   output logic                 out_vld,
   output logic signed [OW-1:0] out_dat
);
   if (DW < 2 || CW < 2) begin : g_bad_width
      $error("tri_lane_fir: DW and CW must each be at least 2");
   end
   if (NLANE < HIST) begin : g_bad_hist
      $error("tri_lane_fir: the block must hold at least NTAP-1 samples");
   end

   logic                 blk_vld;
   logic [NLANE*DW-1:0]  blk_word;
   logic [PHW-1:0]       s2p_phase;
   logic                 y_vld;
   logic [NLANE*OW-1:0]  y_word;
   logic [OW-1:0]        emit_dat;

   fir3_gather #(.DW(DW)) u_gather (
      .clk     (clk),
      .rst     (rst),
      .smp_vld (smp_vld),
      .smp_dat (smp_dat),
      .blk_vld (blk_vld),
      .blk_word(blk_word),
      .phase   (s2p_phase)
   );

   fir3_lanes #(.DW(DW), .CW(CW), .OW(OW), .PROD_REG(PROD_REG)) u_lanes (
      .clk      (clk),
      .rst      (rst),
      .blk_vld  (blk_vld),
      .blk_word (blk_word),
      .coef_flat({coef_c, coef_b, coef_a}),
      .y_vld    (y_vld),
      .y_word   (y_word)
   );

   fir3_emit #(.OW(OW)) u_emit (
      .clk    (clk),
      .rst    (rst),
      .y_vld  (y_vld),
      .y_word (y_word),
      .out_vld(out_vld),
      .out_dat(emit_dat)
   );

   assign out_dat = $signed(emit_dat);
endmodule

// File: rtl/fir3_chk.sv
module fir3_chk #(
   parameter int PHW = 2,
   parameter int DLY = 2
) (
   input logic           clk,
   input logic           rst,
   input logic           smp_vld,
   input logic           blk_vld,
   input logic [PHW-1:0] phase,
   input logic           out_vld
);
   AST_RST_QUIET: assert property (@(posedge clk) rst |=> !out_vld); // R1

   AST_BLK_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
      blk_vld |-> $past(smp_vld)); // R2

   AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
      int'(phase) < 3); // R2

   AST_BURST_THREE: assert property (@(posedge clk) disable iff (rst)
      $rose(out_vld) |-> ##1 out_vld ##1 out_vld); // R7

   AST_BURST_FROM_BLOCK: assert property (@(posedge clk) disable iff (rst)
      $rose(out_vld) |-> $past(blk_vld, DLY)); // R8
endmodule

bind tri_lane_fir fir3_chk #(.PHW(fir3_pkg::PHW), .DLY(2 + int'(PROD_REG))) u_chk (
   .clk    (clk),
   .rst    (rst),
   .smp_vld(smp_vld),
   .blk_vld(blk_vld),
   .phase  (s2p_phase),
   .out_vld(out_vld)
);

// File: tb/sim_tri_lane_fir.sv
module sim_tri_lane_fir;
   localparam int DW = 12;
   localparam int CW = 10;
   localparam int OW = DW + CW + 2;
   localparam int NV = 30;

   // Main table: idle cycles to insert before each sample, then the sample itself.
   localparam int GAP [NV] = '{0,0,0,0,0,0, 0,0,0,0,0,0, 0,1,0,0,2,0,
                               0,4,0,0,0,0, 0,3,0,1,0,0};
   localparam int SMP [NV] = '{1,0,0,0,0,0, 10,10,10,10,10,10,
                               100,-100,100,-100,100,-100, 0,1,2,3,4,5,
                               -2000,2047,-3,777,-1024,61};

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic                 smp_vld = 1'b0;
   logic signed [DW-1:0] smp_dat = '0;
   logic signed [CW-1:0] coef_a = '0, coef_b = '0, coef_c = '0;
   logic                 out_vld;
   logic signed [OW-1:0] out_dat;

   tri_lane_fir u0 (
      .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_dat(smp_dat),
      .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
      .out_vld(out_vld), .out_dat(out_dat)
   );

   always #2 clk = ~clk;

   int     checks = 0, bad = 0, cyc = 0, nout = 0;
   bit     done = 1'b0;
   longint rx1 = 0, rx2 = 0;
   longint pend_y[3];
   int     pend_t[3];
   int     np = 0;
   longint expq[$];
   string  tagq[$];
   int     timq[$];
   string  mode_tag = "";

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Serial reference filter; results are released only once a block is complete.
   task automatic send(input int s);
      longint y;
      @(negedge clk);
      smp_vld = 1'b1;
      smp_dat = s[DW-1:0];
      y = longint'(coef_a) * s + longint'(coef_b) * rx1 + longint'(coef_c) * rx2;
      rx2 = rx1;
      rx1 = s;
      pend_y[np] = y;
      pend_t[np] = cyc;
      np++;
      if (np == 3) begin
         for (int j = 0; j < 3; j++) begin
            expq.push_back(pend_y[j]);
            if (mode_tag != "") tagq.push_back(mode_tag);
            else tagq.push_back(j == 0 ? "R3" : (j == 1 ? "R4" : "R5"));
            // Only the third output of a block carries a latency check (R8).
            timq.push_back(j == 2 ? pend_t[j] : -1);
         end
         np = 0;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         smp_vld = 1'b0;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      smp_vld = 1'b0;
      repeat (3) @(negedge clk);
      chk(out_vld == 1'b0, "R1 out_vld low in reset", longint'(out_vld), 0);
      rx1 = 0; rx2 = 0; np = 0;
      expq.delete(); tagq.delete(); timq.delete();
      rst = 1'b0;
   endtask

   // Output monitor, sampled away from the active edge.
   always @(negedge clk) begin
      if (!rst && out_vld) begin
         longint e;
         string  t;
         int     ti;
         nout++;
         if (expq.size() == 0) begin
            chk(1'b0, "R7 output without a block", longint'(out_dat), 0);
         end else begin
            e  = expq.pop_front();
            t  = tagq.pop_front();
            ti = timq.pop_front();
            chk(longint'(out_dat) == e, t, longint'(out_dat), e);
            if (ti >= 0) chk(cyc - ti == 5, "R8 latency", cyc - ti, 5);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         bad++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      int n0;
      coef_a = 10'sd3; coef_b = -10'sd5; coef_c = 10'sd7;
      do_reset();
      // R1: the first block after reset sees zero history: 15, -25, 35.
      mode_tag = "R1";
      send(5); send(0); send(0);
      idle(8);
      mode_tag = "";
      for (int i = 0; i < NV; i++) begin
         idle(GAP[i]);
         send(SMP[i]);
      end
      idle(10);
      chk(nout == 3 + NV, "R7 output count", nout, 3 + NV);

      // R2: a stranded partial block stays silent.
      n0 = nout;
      send(100); send(-7);
      idle(15);
      chk(nout == n0, "R2 partial block silent", nout, n0);
      // R6: completing it after the gap uses the carried history.
      mode_tag = "R6";
      send(9);
      idle(8);
      chk(nout == n0 + 3, "R7 three outputs per block", nout, n0 + 3);

      // R10: reset in mid-stream drops the partial block and the history.
      mode_tag = "R10";
      send(50);
      do_reset();
      n0 = nout;
      send(1); send(2); send(3);
      idle(8);
      chk(nout == n0 + 3, "R10 one block after reset", nout, n0 + 3);

      // R9: full-scale negative operands on every tap.
      do_reset();
      coef_a = -10'sd512; coef_b = -10'sd512; coef_c = -10'sd512;
      mode_tag = "R9";
      for (int i = 0; i < 6; i++) send(-2048);
      send(2047); send(-2048); send(2047);
      idle(10);
      chk(expq.size() == 0, "R7 all expected outputs seen", expq.size(), 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule